// File: doc/BRIEF.md
# Eight-pin GPIO port with per-pin interrupt detection

This block is a small general-purpose I/O port that sits on a simple APB-style register bus with byte-wide data. Each of its pins can be made an input or an output. A bus master drives outputs and samples pins through a data window. In that window the word address itself serves as a per-bit mask, so software can change or sample any subset of pins in one access without a read-modify-write.

Every pin has its own interrupt detector. Three independent configuration bits select its behaviour. The sense bit chooses level or edge detection. The both-edges bit makes an edge-mode pin fire on either transition. The polarity bit picks high or rising against low or falling. Pad inputs are resynchronised before detection. Edge events stay latched until software acknowledges them with a write-one-to-clear access. Level events track the pin. Raw status, masked status and an enable mask can be read over the bus. A single interrupt line is the OR of the masked status bits.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is 0 (all pins inputs) and `irq` is 0.
- R2: The direction register at byte offset 0x400 drives `pad_oe`: bit n = 1 makes pin n an output, 0 an input. It reads back what was written.
- R3: A write in the data window (offsets 0x000 to 0x3FC) updates output bit n only when address bit n+2 is 1. The other bits keep their value.
- R4: A read in the data window returns the pin values ANDed with address bits [9:2]. Output pins return their driven value. Input pins return the pad level after a two-flop synchroniser.
- R5: With sense (0x404) bit n = 1, raw status bit n follows the pin condition: pin high when polarity (0x40C) bit n is 1, pin low when it is 0. Writing the clear register does not reset it.
- R6: With sense bit n = 0 and both-edges (0x408) bit n = 0, a rising edge (polarity 1) or a falling edge (polarity 0) sets raw bit n. The bit stays set after the pin returns.
- R7: With both-edges bit n = 1 in edge mode, either transition sets raw bit n whatever the polarity bit holds.
- R8: Writing 1 to bit n of the clear register (0x41C) clears a latched edge status. Writing 0 leaves it alone. An edge detected in the same cycle as the clear leaves the bit set.
- R9: Masked status (0x418) equals raw status (0x414) AND enable (0x410). `irq` is 1 exactly when any masked bit is 1.
- R10: Raw status is read-only. A bus write to 0x414 does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid in the access phase |
| pad_in | input | 8 | Pad levels (asynchronous) |
| pad_out | output | 8 | Output values |
| pad_oe | output | 8 | Output enables (1 = drive) |
| irq | output | 1 | Combined interrupt |

## Verification
The data window is driven by a sequence of writes whose address masks are all-ones, a low nibble, a single top bit, a single bottom bit, empty and scattered. This sequence separates a correct mask from one that is ignored, inverted or shifted by a bit. Reads of input, output and mixed-direction pins show whether the readback source is chosen per pin and whether the mask is applied on reads. The detectors are driven with rising and falling transitions under every sense, both-edges and polarity setting, and a pulse returns the pin to its start level. These patterns tell a latched edge from a followed level and one polarity from the other. A clear timed to land on a fresh edge confirms that the new event survives.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned NPIN   = 8;

  // Configuration block starts at byte 0x400; one word per register.
  localparam logic [ADDR_W-1:0] CFG_BASE = 12'h400;

  typedef enum logic [2:0] {
    SEL_DIR    = 3'd0,
    SEL_SENSE  = 3'd1,
    SEL_BOTH   = 3'd2,
    SEL_POL    = 3'd3,
    SEL_EN     = 3'd4,
    SEL_RAW    = 3'd5,
    SEL_MASKED = 3'd6,
    SEL_CLR    = 3'd7
  } cfg_sel_e;
endpackage

// File: rtl/gpio_sync2.sv
// Two-flop resynchroniser plus one history stage for edge detection.
module gpio_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_now,
  output logic [W-1:0] sync_prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] now_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      now_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      now_q  <= meta_q;
      prev_q <= now_q;
    end
  end

  assign sync_now  = now_q;
  assign sync_prev = prev_q;
endmodule

// File: rtl/gpio_pin_detect.sv
// Interrupt detector for one pin.
module gpio_pin_detect (
  input  logic clk,
  input  logic rst,
  input  logic cur,
  input  logic prev,
  input  logic level_mode,
  input  logic any_edge,
  input  logic polarity,
  input  logic clr,
  output logic raw
);
  logic rise;
  logic fall;
  logic edge_hit;
  logic lvl_hit;
  logic raw_q;

  assign rise     = cur & ~prev;
  assign fall     = ~cur & prev;
  assign edge_hit = any_edge ? (rise | fall) : (polarity ? rise : fall);
  assign lvl_hit  = polarity ? cur : ~cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
    end else if (level_mode) begin
      raw_q <= lvl_hit;
    end else if (edge_hit) begin
      raw_q <= 1'b1;
    end else if (clr) begin
      raw_q <= 1'b0;
    end
  end

  assign raw = raw_q;
endmodule

// File: rtl/gpio_regbank.sv
// Bus decode, configuration registers, data window and read-data register.
module gpio_regbank
  import gpio_port_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [N-1:0]  pwdata,
  output logic [N-1:0]  prdata,
  input  logic [N-1:0]  pin_sync,
  input  logic [N-1:0]  raw_stat,
  output logic [N-1:0]  dir_q,
  output logic [N-1:0]  out_q,
  output logic [N-1:0]  sense_q,
  output logic [N-1:0]  both_q,
  output logic [N-1:0]  pol_q,
  output logic [N-1:0]  en_q,
  output logic [N-1:0]  clr_pulse
);
  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = N + 1;
  localparam int unsigned WIN_LO  = N + 2;

  logic          wr_en;
  logic          rd_setup;
  logic          in_window;
  logic          in_cfg;
  cfg_sel_e      sel;
  logic [N-1:0]  addr_mask;
  logic [N-1:0]  pin_view;
  logic [N-1:0]  rd_next;
  logic [N-1:0]  prdata_q;

  assign wr_en     = psel & penable & pwrite;
  assign rd_setup  = psel & ~penable & ~pwrite;
  assign in_window = (paddr[AW-1:WIN_LO] == '0);
  assign in_cfg    = (paddr[AW-1:5] == CFG_BASE[AW-1:5]);
  assign sel       = cfg_sel_e'(paddr[4:2]);
  assign addr_mask = paddr[MASK_HI:MASK_LO];

  // Per-pin readback source: driven value for outputs, pad for inputs.
  assign pin_view = (dir_q & out_q) | (~dir_q & pin_sync);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      out_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
    end else if (wr_en) begin
      if (in_window) begin
        out_q <= (out_q & ~addr_mask) | (pwdata & addr_mask);
      end else if (in_cfg) begin
        case (sel)
          SEL_DIR:   dir_q   <= pwdata;
          SEL_SENSE: sense_q <= pwdata;
          SEL_BOTH:  both_q  <= pwdata;
          SEL_POL:   pol_q   <= pwdata;
          SEL_EN:    en_q    <= pwdata;
          default:   ;
        endcase
      end
    end
  end

  assign clr_pulse = (wr_en && in_cfg && sel == SEL_CLR) ? pwdata : '0;

  always_comb begin
    rd_next = '0;
    if (in_window) begin
      rd_next = pin_view & addr_mask;
    end else if (in_cfg) begin
      case (sel)
        SEL_DIR:    rd_next = dir_q;
        SEL_SENSE:  rd_next = sense_q;
        SEL_BOTH:   rd_next = both_q;
        SEL_POL:    rd_next = pol_q;
        SEL_EN:     rd_next = en_q;
        SEL_RAW:    rd_next = raw_stat;
        SEL_MASKED: rd_next = raw_stat & en_q;
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prdata_q <= '0;
    end else if (rd_setup) begin
      prdata_q <= rd_next;
    end
  end

  assign prdata = prdata_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned N  = NPIN,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [N-1:0]  pwdata,
  output logic [N-1:0]  prdata,
  input  logic [N-1:0]  pad_in,
  output logic [N-1:0]  pad_out,
  output logic [N-1:0]  pad_oe,
  output logic          irq
);
  logic [N-1:0] pin_sync;
  logic [N-1:0] pin_prev;
  logic [N-1:0] raw_stat;
  logic [N-1:0] dir_q;
  logic [N-1:0] out_q;
  logic [N-1:0] sense_q;
  logic [N-1:0] both_q;
  logic [N-1:0] pol_q;
  logic [N-1:0] en_q;
  logic [N-1:0] clr_pulse;

  gpio_sync2 #(.W(N)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .async_in  (pad_in),
    .sync_now  (pin_sync),
    .sync_prev (pin_prev)
  );

  gpio_regbank #(.N(N), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .pin_sync  (pin_sync),
    .raw_stat  (raw_stat),
    .dir_q     (dir_q),
    .out_q     (out_q),
    .sense_q   (sense_q),
    .both_q    (both_q),
    .pol_q     (pol_q),
    .en_q      (en_q),
    .clr_pulse (clr_pulse)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    gpio_pin_detect u_det (
      .clk        (clk),
      .rst        (rst),
      .cur        (pin_sync[i]),
      .prev       (pin_prev[i]),
      .level_mode (sense_q[i]),
      .any_edge   (both_q[i]),
      .polarity   (pol_q[i]),
      .clr        (clr_pulse[i]),
      .raw        (raw_stat[i])
    );
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign irq     = |(raw_stat & en_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [N-1:0]  pwdata,
  input logic [N-1:0]  pad_out,
  input logic [N-1:0]  pad_oe,
  input logic          irq,
  input logic [N-1:0]  raw_stat,
  input logic [N-1:0]  en_q,
  input logic [N-1:0]  sense_q,
  input logic [N-1:0]  pol_q,
  input logic [N-1:0]  pin_sync
);
  logic wr;
  assign wr = psel & penable & pwrite;

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && paddr == 12'h400) |=> (pad_oe == $past(pwdata)));

  // R3
  masked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && paddr[AW-1:N+2] == '0) |=>
      (pad_out == (($past(pad_out) & ~$past(paddr[N+1:2])) |
                   ($past(pwdata) & $past(paddr[N+1:2])))));

  // R5
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_stat & $past(sense_q)) ==
              ($past(sense_q) & ~($past(pin_sync) ^ $past(pol_q)))));

  // R9
  irq_combine_chk: assert property (@(posedge clk) disable iff (rst)
    irq == ((raw_stat & en_q) != '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N(N), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .irq      (irq),
  .raw_stat (raw_stat),
  .en_q     (en_q),
  .sense_q  (sense_q),
  .pol_q    (pol_q),
  .pin_sync (pin_sync)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata, pad_out, pad_oe;
  logic [7:0]  pad_in = '0;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  logic [7:0]  rd;

  // {address mask, write data, expected full readback}
  localparam logic [23:0] VEC [6] = '{
    {8'hFF, 8'hA5, 8'hA5},
    {8'h0F, 8'h3C, 8'hAC},
    {8'h80, 8'h00, 8'h2C},
    {8'h01, 8'hFF, 8'h2D},
    {8'h00, 8'hFF, 8'h2D},
    {8'h5A, 8'hFF, 8'h7F}
  };

  always #5 clk = ~clk;

  gpio_irq_port uut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    for (int k = 0; k < 8; k++) begin
      bus_rd(12'h400 + 12'(4 * k), rd);
      check("R1 register", rd, 8'h00);
    end

    // R2 direction
    bus_wr(12'h400, 8'hFF);
    check("R2 pad_oe", pad_oe, 8'hFF);
    bus_rd(12'h400, rd);
    check("R2 readback", rd, 8'hFF);

    // R3 masked writes, vector walk
    for (int v = 0; v < 6; v++) begin
      bus_wr({2'b00, VEC[v][23:16], 2'b00}, VEC[v][15:8]);
      check("R3 pad_out", pad_out, VEC[v][7:0]);
      bus_rd({2'b00, 8'hFF, 2'b00}, rd);
      check("R3 readback", rd, VEC[v][7:0]);
    end

    // R4 masked reads, inputs and mixed direction
    bus_rd({2'b00, 8'h0F, 2'b00}, rd);
    check("R4 partial mask", rd, 8'h0F);
    bus_wr(12'h400, 8'h00);
    pad_in = 8'h96; settle();
    bus_rd({2'b00, 8'hFF, 2'b00}, rd);
    check("R4 input pins", rd, 8'h96);
    bus_rd({2'b00, 8'h0F, 2'b00}, rd);
    check("R4 input masked", rd, 8'h06);
    bus_wr(12'h400, 8'hF0);
    bus_rd({2'b00, 8'hFF, 2'b00}, rd);
    check("R4 mixed", rd, 8'h76);
    bus_wr(12'h400, 8'h00);
    pad_in = 8'h00; settle();
    bus_wr(12'h41C, 8'hFF);

    // R5 level mode on pin 0 (high) and pin 1 (low)
    bus_wr(12'h40C, 8'h01);
    bus_wr(12'h404, 8'h03);
    settle();
    bus_rd(12'h414, rd);
    check("R5 low pins", rd & 8'h03, 8'h02);
    pad_in = 8'h03; settle();
    bus_rd(12'h414, rd);
    check("R5 high pins", rd & 8'h03, 8'h01);
    bus_wr(12'h41C, 8'h01);
    bus_rd(12'h414, rd);
    check("R5 clear ignored", rd & 8'h03, 8'h01);
    pad_in = 8'h00;
    bus_wr(12'h404, 8'h00);
    bus_wr(12'h40C, 8'h00);
    settle();
    bus_wr(12'h41C, 8'hFF);
    bus_rd(12'h414, rd);
    check("R8 clear all", rd, 8'h00);

    // R6 single edges: pin 2 rising, pin 3 falling
    bus_wr(12'h40C, 8'h04);
    pad_in = 8'h08; settle();
    bus_wr(12'h41C, 8'hFF);
    pad_in = 8'h04; settle();
    bus_rd(12'h414, rd);
    check("R6 rise and fall", rd, 8'h0C);
    pad_in = 8'h08; settle();
    bus_rd(12'h414, rd);
    check("R6 latched", rd, 8'h0C);
    bus_wr(12'h41C, 8'h00);
    bus_rd(12'h414, rd);
    check("R8 zero write", rd, 8'h0C);
    bus_wr(12'h41C, 8'h04);
    bus_rd(12'h414, rd);
    check("R8 single clear", rd, 8'h08);
    bus_wr(12'h41C, 8'hFF);

    // R10 raw is read-only
    pad_in = 8'h00; settle();
    bus_wr(12'h41C, 8'hFF);
    bus_wr(12'h414, 8'hFF);
    bus_rd(12'h414, rd);
    check("R10 raw write ignored", rd, 8'h00);

    // R7 both edges on pin 4, polarity says rising
    bus_wr(12'h408, 8'h10);
    bus_wr(12'h40C, 8'h10);
    pad_in = 8'h10; settle();
    bus_rd(12'h414, rd);
    check("R7 rising", rd & 8'h10, 8'h10);
    bus_wr(12'h41C, 8'h10);
    pad_in = 8'h00; settle();
    bus_rd(12'h414, rd);
    check("R7 falling", rd & 8'h10, 8'h10);

    // R9 mask and combined output
    check("R9 irq masked off", {7'b0, irq}, 8'h00);
    bus_wr(12'h410, 8'h11);
    bus_rd(12'h418, rd);
    check("R9 masked status", rd, 8'h10);
    check("R9 irq on", {7'b0, irq}, 8'h01);
    bus_wr(12'h41C, 8'h10);
    check("R9 irq off", {7'b0, irq}, 8'h00);

    // R8 clear and fresh edge in the same cycle: pin 4, latched first
    pad_in = 8'h10; settle();
    pad_in = 8'h00; settle();
    @(negedge clk); pad_in = 8'h10;
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = 12'h41C; pwdata = 8'h10;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    bus_rd(12'h414, rd);
    check("R8 edge wins", rd & 8'h10, 8'h10);
    bus_wr(12'h41C, 8'h10);
    bus_rd(12'h414, rd);
    check("R8 cleared after", rd & 8'h10, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule